// File: doc/BRIEF.md
# Hiccup Fault-Recovery Sequencer

This block supervises start-up and fault recovery of a peak-current-mode switching converter. It moves through four states: off, soft-start, run and hiccup. It tells the PWM generator when switching must stop, when the soft-start node must be held discharged, and when only the low-side switch may pulse. In that last mode the primary capacitor is pulled toward zero through a reduced sink-current limit. The analog soft-start ramp is outside the block. A done flag stands in for it.

Three causes start a hiccup. The first is a single runaway current-limit event. The second is the output-undervoltage flag, which counts only after soft-start has finished. The third is a run of consecutive switching cycles that each ended in a sink current-limit event. A hiccup lasts a fixed number of switching cycles, marked by `cycle_tick`. After it, soft-start begins again from zero. A register keeps the cause of the latest hiccup. Enable low or an over-temperature flag sends the block to off. From off, a restart goes through soft-start.

Top module: `hiccup_sequencer`

## Requirements
- R1: After reset, `state_o` is 0 (off), `sw_inhibit` and `ss_discharge` are 1, `lowside_only` is 0, and `fault_cause` is 0.
- R2: The state codes are 0 = off, 1 = soft-start, 2 = run and 3 = hiccup. With `enable` high and `ot_flag` low, off goes to soft-start on the next clock. Soft-start goes to run on the clock where `ss_done` is high. In soft-start and run, `sw_inhibit`, `ss_discharge` and `lowside_only` are 0.
- R3: A `runaway_evt` seen in soft-start or run enters hiccup on the next clock and sets `fault_cause` to 1. The same event has no effect in off.
- R4: `uv_flag` in run enters hiccup on the next clock and sets `fault_cause` to 2. `uv_flag` in soft-start is ignored and the state stays soft-start.
- R5: NEG_RUN consecutive switching cycles (default 16) that each hold a `neg_lim_evt` enter hiccup and set `fault_cause` to 3. A cycle without that event restarts the count.
- R6: Hiccup lasts exactly TIMEOUT_CYCLES ticks of `cycle_tick` (default 32768), then soft-start follows. During hiccup, `sw_inhibit`, `ss_discharge` and `lowside_only` are all 1.
- R7: `enable` low moves any state to off on the next clock. Off holds `sw_inhibit` and `ss_discharge` at 1 and `lowside_only` at 0.
- R8: `ot_flag` high moves the block to off and keeps it there. A restart into soft-start happens only on the clock after the flag clears.
- R9: `fault_cause` changes only when a hiccup is entered. It keeps its value through off, soft-start and run.
- R10: Entering hiccup clears the sink-limit count, so after recovery a run shorter than NEG_RUN does not trigger another hiccup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter enable |
| cycle_tick | input | 1 | One-clock pulse marking the end of a switching cycle |
| ss_done | input | 1 | Soft-start ramp has finished |
| uv_flag | input | 1 | Output below the undervoltage trip level |
| ot_flag | input | 1 | Over-temperature shutdown request |
| runaway_evt | input | 1 | Runaway current-limit event pulse |
| neg_lim_evt | input | 1 | Sink current-limit event pulse |
| sw_inhibit | output | 1 | High-side switching must stay off |
| ss_discharge | output | 1 | Hold the soft-start node discharged |
| lowside_only | output | 1 | PWM pulses only the low-side switch at the reduced sink limit |
| state_o | output | 2 | Current state code |
| fault_cause | output | 2 | Cause of the latest hiccup: 0 none, 1 runaway, 2 undervoltage, 3 sink-limit run |

## Verification
The assertions check, on every cycle, the transitions that follow directly from one input:
- a runaway event in soft-start or run leads to hiccup with cause 1;
- enable low and over-temperature force off;
- off can move only to soft-start;
- hiccup exits only to soft-start or off;
- the undervoltage flag never causes a hiccup from soft-start;
- the cause register holds except on hiccup entry.

The hiccup length, the consecutive-cycle count with its restart on a quiet cycle, and the count cleared after recovery all depend on long histories. Only the bench's scenarios exercise those.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_SS   = 2'd1,
        ST_RUN  = 2'd2,
        ST_HIC  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_RUNAWAY  = 2'd1,
        CAUSE_UV       = 2'd2,
        CAUSE_NEGRUN   = 2'd3
    } fault_cause_e;

    typedef struct packed {
        seq_state_e   state;
        fault_cause_e cause;
    } seq_regs_t;

endpackage

// File: rtl/hiccup_neg_streak.sv
// Counts consecutive switching cycles that each contained a sink-limit event.
module hiccup_neg_streak #(
    parameter int NEG_RUN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic evt,
    output logic hit
);
    localparam int SW = (NEG_RUN > 2) ? $clog2(NEG_RUN) : 1;

    typedef struct packed {
        logic [SW-1:0] cnt;
        logic          seen;
    } streak_t;

    streak_t cur_q, nxt_d;
    logic    cycle_had;

    always_comb begin
        nxt_d     = cur_q;
        cycle_had = cur_q.seen | evt;
        hit       = tick && cycle_had && (cur_q.cnt == SW'(NEG_RUN - 1));
        if (clear) begin
            nxt_d.cnt  = '0;
            nxt_d.seen = 1'b0;
        end else if (tick) begin
            nxt_d.seen = 1'b0;
            if (!cycle_had || hit) nxt_d.cnt = '0;
            else                   nxt_d.cnt = cur_q.cnt + 1'b1;
        end else if (evt) begin
            nxt_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/hiccup_timer.sv
// Counts switching cycles while the sequencer sits in hiccup.
module hiccup_timer #(
    parameter int TIMEOUT_CYCLES = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expire
);
    localparam int TW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;

    logic [TW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d  = cnt_q;
        expire = tick && (cnt_q == TW'(TIMEOUT_CYCLES - 1));
        if (clear)       cnt_d = '0;
        else if (expire) cnt_d = '0;
        else if (tick)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hiccup_sequencer.sv
module hiccup_sequencer
    import hiccup_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 32768,
    parameter int NEG_RUN        = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       cycle_tick,
    input  logic       ss_done,
    input  logic       uv_flag,
    input  logic       ot_flag,
    input  logic       runaway_evt,
    input  logic       neg_lim_evt,
    output logic       sw_inhibit,
    output logic       ss_discharge,
    output logic       lowside_only,
    output logic [1:0] state_o,
    output logic [1:0] fault_cause
);
    seq_regs_t cur_q, nxt_d;
    logic      streak_clear, streak_hit;
    logic      timer_clear, timer_expire;
    logic      active;

    assign active       = (cur_q.state == ST_SS) || (cur_q.state == ST_RUN);
    assign streak_clear = !active;
    assign timer_clear  = (cur_q.state != ST_HIC);

    hiccup_neg_streak #(.NEG_RUN(NEG_RUN)) i_streak (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (streak_clear),
        .tick  (cycle_tick),
        .evt   (neg_lim_evt),
        .hit   (streak_hit)
    );

    hiccup_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (timer_clear),
        .tick   (cycle_tick),
        .expire (timer_expire)
    );

    always_comb begin
        nxt_d = cur_q;
        if (!enable || ot_flag) begin
            nxt_d.state = ST_OFF;
        end else begin
            unique case (cur_q.state)
                ST_OFF: nxt_d.state = ST_SS;
                ST_SS, ST_RUN: begin
                    if (runaway_evt) begin
                        nxt_d.state = ST_HIC;
                        nxt_d.cause = CAUSE_RUNAWAY;
                    end else if ((cur_q.state == ST_RUN) && uv_flag) begin
                        nxt_d.state = ST_HIC;
                        nxt_d.cause = CAUSE_UV;
                    end else if (streak_hit) begin
                        nxt_d.state = ST_HIC;
                        nxt_d.cause = CAUSE_NEGRUN;
                    end else if ((cur_q.state == ST_SS) && ss_done) begin
                        nxt_d.state = ST_RUN;
                    end
                end
                ST_HIC: if (timer_expire) nxt_d.state = ST_SS;
                default: nxt_d.state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_OFF;
            cur_q.cause <= CAUSE_NONE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sw_inhibit   = !active;
    assign ss_discharge = !active;
    assign lowside_only = (cur_q.state == ST_HIC);
    assign state_o      = cur_q.state;
    assign fault_cause  = cur_q.cause;
endmodule

// File: rtl/hiccup_sequencer_chk.sv
module hiccup_sequencer_chk
    import hiccup_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       ot_flag,
    input logic       uv_flag,
    input logic       runaway_evt,
    input logic       sw_inhibit,
    input logic       ss_discharge,
    input logic       lowside_only,
    input logic [1:0] state_o,
    input logic [1:0] fault_cause
);
    logic in_active;
    assign in_active = (state_o == ST_SS) || (state_o == ST_RUN);

    // R3
    runaway_enters_hiccup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !ot_flag && runaway_evt && in_active)
        |=> (state_o == ST_HIC) && (fault_cause == CAUSE_RUNAWAY));

    // R7
    disable_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_o == ST_OFF));

    // R8
    overtemp_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> (state_o == ST_OFF));

    // R2
    off_exits_to_softstart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_OFF) |=> (state_o == ST_OFF) || (state_o == ST_SS));

    // R6
    hiccup_exit_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_HIC) |=> (state_o != ST_RUN));

    // R4
    uv_masked_in_softstart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_SS && uv_flag && enable && !ot_flag && !runaway_evt)
        |=> !((state_o == ST_HIC) && (fault_cause == CAUSE_UV)));

    // R9
    cause_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(state_o == ST_HIC) |-> $stable(fault_cause));

    // R6
    discharge_mode_inhibits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lowside_only |-> (sw_inhibit && ss_discharge));
endmodule

bind hiccup_sequencer hiccup_sequencer_chk i_chk (.*);

// File: tb/test_hiccup_sequencer.sv
module test_hiccup_sequencer;
    localparam int TMO = 40;
    localparam int NRUN = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, cycle_tick = 1'b1, ss_done = 1'b0, uv_flag = 1'b0;
    logic ot_flag = 1'b0, runaway_evt = 1'b0, neg_lim_evt = 1'b0;
    logic sw_inhibit, ss_discharge, lowside_only;
    logic [1:0] state_o, fault_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hiccup_sequencer #(.TIMEOUT_CYCLES(TMO), .NEG_RUN(NRUN)) i_hiccup_sequencer (
        .clk, .rst_n, .enable, .cycle_tick, .ss_done, .uv_flag, .ot_flag,
        .runaway_evt, .neg_lim_evt, .sw_inhibit, .ss_discharge, .lowside_only,
        .state_o, .fault_cause
    );

    // fields: en, ss_done, uv, ot, runaway, neg, expected state[1:0]
    localparam logic [7:0] VEC [10] = '{
        8'b1_0_0_0_0_0_01,  // R2 off -> soft-start
        8'b1_0_1_0_0_0_01,  // R4 uv masked in soft-start
        8'b1_1_0_0_0_0_10,  // R2 soft-start -> run
        8'b1_1_0_1_0_0_00,  // R8 over-temp -> off
        8'b1_0_0_1_0_0_00,  // R8 held off while hot
        8'b1_0_0_0_0_0_01,  // R8 restart after clear
        8'b1_1_0_0_0_0_10,  // R2 run again
        8'b0_0_0_0_0_0_00,  // R7 enable low -> off
        8'b1_0_0_0_1_0_01,  // R3 runaway ignored in off
        8'b1_0_0_0_1_0_11   // R3 runaway in soft-start -> hiccup
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic quiet();
        ss_done = 0; uv_flag = 0; ot_flag = 0; runaway_evt = 0; neg_lim_evt = 0;
        enable = 1;
    endtask

    task automatic check_outs(input string req, input int s);
        chk({req, " state"}, state_o, s);
        chk({req, " inhibit"}, sw_inhibit, (s == 1 || s == 2) ? 0 : 1);
        chk({req, " discharge"}, ss_discharge, (s == 1 || s == 2) ? 0 : 1);
        chk({req, " lowside"}, lowside_only, (s == 3) ? 1 : 0);
    endtask

    // wait out a hiccup entered on the previous step; checks its length (R6)
    task automatic ride_hiccup();
        quiet();
        for (int k = 1; k < TMO; k++) begin
            step();
            chk("R6 hiccup held", state_o, 3);
        end
        step();
        check_outs("R6 hiccup exit", 1);
    endtask

    task automatic reach_run();
        quiet();
        ss_done = 1;
        step();
        chk("R2 reach run", state_o, 2);
        ss_done = 0;
    endtask

    initial begin
        #5;
        step();
        check_outs("R1 reset", 0);
        chk("R1 cause", fault_cause, 0);
        rst_n = 1;
        #20;

        for (int i = 0; i < 10; i++) begin
            enable = VEC[i][7]; ss_done = VEC[i][6]; uv_flag = VEC[i][5];
            ot_flag = VEC[i][4]; runaway_evt = VEC[i][3]; neg_lim_evt = VEC[i][2];
            step();
            check_outs($sformatf("R2/R3/R4/R7/R8 vector %0d", i), VEC[i][1:0]);
        end
        chk("R3 cause runaway", fault_cause, 1);
        ride_hiccup();
        chk("R9 cause kept", fault_cause, 1);

        // undervoltage in run
        reach_run();
        uv_flag = 1;
        step();
        check_outs("R4 uv in run", 3);
        chk("R4 cause uv", fault_cause, 2);
        ride_hiccup();

        // sink-limit run broken by one quiet cycle
        reach_run();
        neg_lim_evt = 1;
        for (int k = 0; k < NRUN - 1; k++) step();
        chk("R5 short run no trip", state_o, 2);
        neg_lim_evt = 0;
        step();
        neg_lim_evt = 1;
        for (int k = 0; k < NRUN - 1; k++) step();
        chk("R5 count restarted", state_o, 2);
        step();
        check_outs("R5 full run trips", 3);
        chk("R5 cause", fault_cause, 3);
        ride_hiccup();

        // count cleared by hiccup entry
        reach_run();
        neg_lim_evt = 1;
        for (int k = 0; k < NRUN - 1; k++) step();
        chk("R10 count cleared", state_o, 2);
        neg_lim_evt = 0;
        step();

        // enable low during hiccup, cause retained
        runaway_evt = 1;
        step();
        chk("R3 runaway in run", state_o, 3);
        quiet();
        enable = 0;
        step();
        check_outs("R7 enable low in hiccup", 0);
        chk("R9 cause through off", fault_cause, 1);
        enable = 1;
        uv_flag = 1;
        step();
        chk("R4 uv ignored off", state_o, 1);
        step();
        chk("R4 uv ignored soft-start", state_o, 1);
        chk("R9 cause unchanged", fault_cause, 1);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule